// File: doc/BRIEF.md
# Dual-Read Single-Write Register File with Hardwired Zero

This block is the operand store for a register-to-register datapath. Every arithmetic operand is read from it, and every result is written back into it. It holds a power-of-two number of registers (32 by default, each 32 bits wide). Each instruction can read two source operands through two independent combinational read ports and write one destination through a single write port, which updates on the rising clock edge.

Register number 0 is a constant: it always reads as zero and keeps no state, and any write aimed at it is dropped. Software can therefore use it as a zero source for moves and comparisons. A build-time switch decides what a read returns when it hits the register being written in the same cycle. With the switch off, the read returns the stored (old) value. With it on, the incoming write data is forwarded onto the read port.

Top module: `regfile_3p`

## Requirements
- R1: While `rst` is high at a rising clock edge, every register is cleared to zero (synchronous, active-high reset), and any write requested in that cycle is ignored.
- R2: When `wr_en` is 1 and `wr_idx` is nonzero at a rising edge, `wr_val` is stored in register `wr_idx` and is returned by either read port addressing that register from the next cycle onward.
- R3: When `wr_en` is 0 at a rising edge, no register changes, whatever `wr_idx` and `wr_val` hold.
- R4: A read of index 0 on either port always returns zero, including after a write to index 0 has been attempted.
- R5: The two read ports are independent. Each returns the content of the register it addresses, combinationally within the same cycle, even when the two ports address different registers or the same register.
- R6: With `FWD_EN` = 0, a read of the register being written in the same cycle returns the value held before that edge.
- R7: With `FWD_EN` = 1, a read whose index equals a nonzero `wr_idx` while `wr_en` is 1 returns `wr_val` in that same cycle. A read of index 0 still returns zero.
- R8: A write changes only the addressed register. In particular, writes to index 31 and index 1 leave their neighbours untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and reset act on the rising edge |
| rst | input | 1 | Synchronous active-high reset that clears all registers |
| wr_en | input | 1 | Write request for the current cycle |
| wr_idx | input | IDX_W (5) | Destination register number |
| wr_val | input | DATA_W (32) | Data to be written |
| rd_idx_a | input | IDX_W (5) | Register number for read port A |
| rd_val_a | output | DATA_W (32) | Combinational data of read port A |
| rd_idx_b | input | IDX_W (5) | Register number for read port B |
| rd_val_b | output | DATA_W (32) | Combinational data of read port B |

## Verification
The case that matters is a write and a read of the same register landing in one cycle. The bench provokes it with directed collisions and with a random phase in which about half the reads copy the write index. Two instances are driven with the same stimulus: one with forwarding off and one with it on. Each read value is compared with a bench array model that takes the pre-edge value for the first instance and the forwarded data for the second. Index 0 is pinned to zero in both cases.

// File: rtl/rf_pkg.sv
package rf_pkg;
  typedef enum logic {
    RD_STORED = 1'b0,
    RD_FORWARD = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/rf_wr_decode.sv
module rf_wr_decode #(
  parameter int IDX_W = 5,
  localparam int NREG = 1 << IDX_W
) (
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  output logic [NREG-1:0]  wr_sel
);
  // slot 0 has no storage and is never selected
  assign wr_sel[0] = 1'b0;
  for (genvar i = 1; i < NREG; i++) begin : g_sel
    assign wr_sel[i] = wr_en && (wr_idx == IDX_W'(i));
  end
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
  import rf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W = 5,
  parameter rd_mode_e MODE = RD_STORED,
  localparam int NREG = 1 << IDX_W
) (
  input  logic [DATA_W-1:0] regs [NREG],
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_val,
  output logic [DATA_W-1:0] rd_val
);
  logic hit;

  if (MODE == RD_FORWARD) begin : g_fwd
    assign hit = wr_en && (wr_idx == rd_idx);
  end else begin : g_nofwd
    logic unused_fwd;
    assign unused_fwd = wr_en ^ (^wr_idx) ^ (^wr_val);
    assign hit = 1'b0;
  end

  always_comb begin
    if (rd_idx == '0)
      rd_val = '0;
    else if (hit)
      rd_val = wr_val;
    else
      rd_val = regs[rd_idx];
  end
endmodule

// File: rtl/regfile_3p.sv
module regfile_3p
  import rf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W = 5,
  parameter bit FWD_EN = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_val,
  input  logic [IDX_W-1:0]  rd_idx_a,
  output logic [DATA_W-1:0] rd_val_a,
  input  logic [IDX_W-1:0]  rd_idx_b,
  output logic [DATA_W-1:0] rd_val_b
);
  localparam int NREG = 1 << IDX_W;
  localparam rd_mode_e MODE = FWD_EN ? RD_FORWARD : RD_STORED;

  logic [NREG-1:0]   wr_sel;
  logic [DATA_W-1:0] regs [NREG];

  rf_wr_decode #(.IDX_W(IDX_W)) u_dec (
    .wr_en (wr_en),
    .wr_idx(wr_idx),
    .wr_sel(wr_sel)
  );

  // index 0 is a constant, no flop behind it
  assign regs[0] = '0;

  for (genvar i = 1; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs[i] <= '0;
      else if (wr_sel[i])
        regs[i] <= wr_val;
    end
  end

  rf_read_port #(.DATA_W(DATA_W), .IDX_W(IDX_W), .MODE(MODE)) u_rd_a (
    .regs  (regs),
    .rd_idx(rd_idx_a),
    .wr_en (wr_en),
    .wr_idx(wr_idx),
    .wr_val(wr_val),
    .rd_val(rd_val_a)
  );

  rf_read_port #(.DATA_W(DATA_W), .IDX_W(IDX_W), .MODE(MODE)) u_rd_b (
    .regs  (regs),
    .rd_idx(rd_idx_b),
    .wr_en (wr_en),
    .wr_idx(wr_idx),
    .wr_val(wr_val),
    .rd_val(rd_val_b)
  );
endmodule

// File: rtl/regfile_3p_chk.sv
module regfile_3p_chk #(
  parameter int DATA_W = 32,
  parameter int IDX_W = 5,
  parameter bit FWD_EN = 1'b0
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [IDX_W-1:0]  wr_idx,
  input logic [DATA_W-1:0] wr_val,
  input logic [IDX_W-1:0]  rd_idx_a,
  input logic [DATA_W-1:0] rd_val_a,
  input logic [IDX_W-1:0]  rd_idx_b,
  input logic [DATA_W-1:0] rd_val_b
);
  logic fwd_a, fwd_b;
  assign fwd_a = FWD_EN && wr_en && (wr_idx == rd_idx_a) && (rd_idx_a != '0);
  assign fwd_b = FWD_EN && wr_en && (wr_idx == rd_idx_b) && (rd_idx_b != '0);

  // R4: index 0 reads as zero on both ports
  assert_zero_a_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_idx_a == '0) |-> (rd_val_a == '0));
  assert_zero_b_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_idx_b == '0) |-> (rd_val_b == '0));

  // R1: first cycle after reset everything reads zero
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && !fwd_a) |-> (rd_val_a == '0));

  // R2: a committed write is visible next cycle
  assert_write_seen_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en) && ($past(wr_idx) != '0)
     && (rd_idx_b == $past(wr_idx)) && !fwd_b) |-> (rd_val_b == $past(wr_val)));

  // R3: without a write and with a steady index the read value holds
  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_en) && $stable(rd_idx_a) && !fwd_a
     && !$past(fwd_a)) |-> $stable(rd_val_a));

  // R7: forwarding presents the incoming data
  assert_forward_R7: assert property (@(posedge clk) disable iff (rst)
    fwd_b |-> (rd_val_b == wr_val));
endmodule

bind regfile_3p regfile_3p_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W), .FWD_EN(FWD_EN)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_val(wr_val),
  .rd_idx_a(rd_idx_a), .rd_val_a(rd_val_a), .rd_idx_b(rd_idx_b), .rd_val_b(rd_val_b)
);

// File: tb/tb_regfile_3p.sv
module tb_regfile_3p;
  localparam int CLK_P = 10;
  localparam int DW = 32;
  localparam int AW = 5;
  localparam int NR = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_idx = '0;
  logic [DW-1:0] wr_val = '0;
  logic [AW-1:0] rd_idx_a = '0;
  logic [AW-1:0] rd_idx_b = '0;
  logic [DW-1:0] rd_val_a, rd_val_b, fa, fb;

  logic [DW-1:0] model [NR];
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  regfile_3p #(.DATA_W(DW), .IDX_W(AW), .FWD_EN(1'b0)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_val(wr_val),
    .rd_idx_a(rd_idx_a), .rd_val_a(rd_val_a), .rd_idx_b(rd_idx_b), .rd_val_b(rd_val_b));

  regfile_3p #(.DATA_W(DW), .IDX_W(AW), .FWD_EN(1'b1)) dut_fwd (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_val(wr_val),
    .rd_idx_a(rd_idx_a), .rd_val_a(fa), .rd_idx_b(rd_idx_b), .rd_val_b(fb));

  function automatic logic [DW-1:0] expect_rd(input logic [AW-1:0] ri, input bit fwd);
    if (ri == '0) return '0;
    if (fwd && wr_en && wr_idx == ri) return wr_val;
    return model[ri];
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive on the falling edge, check just after, commit on the rising edge
  task automatic step(input string req, input bit we, input logic [AW-1:0] wi,
                      input logic [DW-1:0] wv, input logic [AW-1:0] ra, input logic [AW-1:0] rb);
    @(negedge clk);
    wr_en = we; wr_idx = wi; wr_val = wv; rd_idx_a = ra; rd_idx_b = rb;
    #1;
    check(req, rd_val_a, expect_rd(ra, 1'b0));
    check(req, rd_val_b, expect_rd(rb, 1'b0));
    check(req, fa, expect_rd(ra, 1'b1));
    check(req, fb, expect_rd(rb, 1'b1));
    @(posedge clk);
    if (we && wi != '0) model[wi] = wv;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b1; wr_idx = 5'd3; wr_val = 32'hDEAD_BEEF;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0; wr_en = 1'b0;
    for (int i = 0; i < NR; i++) model[i] = '0;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NR; i++) model[i] = 32'hFFFF_FFFF;
    // R1: registers dirty first, then reset clears them and ignores the write
    rst = 1'b0;
    for (int i = 1; i < NR; i++) begin
      @(negedge clk); wr_en = 1'b1; wr_idx = AW'(i); wr_val = 32'h5500_0000 | i;
    end
    do_reset();
    for (int i = 0; i < NR; i += 2) step("R1", 1'b0, 5'd0, '0, AW'(i), AW'(i + 1));

    // R2: plain write then read
    step("R2", 1'b1, 5'd5, 32'hA5A5_5A5A, 5'd0, 5'd0);
    step("R2", 1'b0, 5'd0, '0, 5'd5, 5'd5);
    // R4: write to zero is dropped
    step("R4", 1'b1, 5'd0, 32'hFFFF_FFFF, 5'd0, 5'd0);
    step("R4", 1'b0, 5'd0, '0, 5'd0, 5'd5);
    // R6 / R7: same-cycle collision on both ports
    step("R6_R7", 1'b1, 5'd7, 32'h1234_5678, 5'd7, 5'd7);
    step("R6_R7", 1'b1, 5'd7, 32'h8765_4321, 5'd7, 5'd0);
    step("R6_R7", 1'b0, 5'd0, '0, 5'd7, 5'd7);
    // R3: disabled write carries an address and data
    step("R3", 1'b0, 5'd5, 32'h0BAD_0BAD, 5'd5, 5'd7);
    step("R3", 1'b0, 5'd0, '0, 5'd5, 5'd7);
    // R8: boundary registers and their neighbours
    step("R8", 1'b1, 5'd31, 32'hC0DE_0031, 5'd30, 5'd31);
    step("R8", 1'b1, 5'd1, 32'hC0DE_0001, 5'd31, 5'd2);
    step("R8", 1'b0, 5'd0, '0, 5'd1, 5'd30);
    step("R8", 1'b0, 5'd0, '0, 5'd2, 5'd31);
    // R5: random traffic, many collisions
    for (int n = 0; n < 3000; n++) begin
      logic [AW-1:0] wi, ra, rb;
      wi = AW'($urandom);
      ra = ($urandom % 2) ? wi : AW'($urandom);
      rb = ($urandom % 3 == 0) ? ra : AW'($urandom);
      step("R5", ($urandom % 4) != 0, wi, $urandom, ra, rb);
    end
    // R1: reset again after traffic
    do_reset();
    for (int i = 0; i < NR; i += 2) step("R1", 1'b0, 5'd0, '0, AW'(i + 1), AW'(i));

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule